// File: doc/BRIEF.md
# Load/Store Alignment and Fault Checker

This block sits in the memory stage of a 32-bit load/store pipeline. Each cycle it may receive one decoded memory request, made of a valid flag, a load-or-store flag, the width code, the effective address, and a flag that marks a compressed-form word access. It works out the access size and tests the address for natural alignment. It only lets an access onto the bus when the access is legal and aligned. A misaligned or illegal access never reaches the bus.

The bus model is single-cycle. The read data and the error flag come back in the same cycle as the request. For loads, the checker sign- or zero-extends the returned data for the register write, and it turns a bus error into an access-fault cause. It produces one registered result pulse per request:
- an exception with a 4-bit cause code, or
- a completed access, which for loads also carries the extended write-back data.

Top module: `lsu_align_check`

## Requirements
- R1: The size in bytes is 1 << width[1:0] (1, 2 or 4). A compressed request is always 4 bytes, whatever its width code. A legal, aligned request drives `bus_req_valid` high in its own cycle, with `bus_req_write` equal to `req_is_store` and `bus_req_addr` equal to `req_addr`.
- R2: A load whose address AND (size-1) is nonzero raises cause 4. It issues no bus request and raises no `wb_valid`.
- R3: An aligned load that sees `bus_rsp_error` high raises cause 5 and raises no `wb_valid`.
- R4: A misaligned store raises cause 6 and issues no bus request.
- R5: An aligned, legal store issues the bus write and produces a `done_valid` pulse with no exception. `bus_rsp_error` has no effect on stores.
- R6: A successful load extends `bus_rsp_data` according to its width code:
  - 0: sign-extends bits 7:0.
  - 1: sign-extends bits 15:0.
  - 2: passes the whole word.
  - 4: zero-extends bits 7:0.
  - 5: zero-extends bits 15:0.
- R7: A compressed load or store uses the 4-byte alignment test (address bits 1:0 both zero) and the same causes 4, 5 and 6. A compressed load passes the whole word, and its width code is ignored.
- R8: Causes are ranked by priority: illegal (2) first, then misaligned (4/6), then bus fault (5). A bus error on a misaligned or illegal request is never reported.
- R9: Width codes 3, 6 and 7 on a load, and codes 3 to 7 on a store, are illegal when the request is not compressed. Such a request raises cause 2 and issues no bus request.
- R10: `exc_valid`, `exc_cause`, `wb_valid`, `wb_data` and `done_valid` are registered. They appear on the cycle after the request and last one cycle. When `exc_valid` is low, `exc_cause` is 0, and when `wb_valid` is low, `wb_data` is 0. Reset clears all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_compressed | input | 1 | Compressed-form word access |
| req_width | input | 3 | Width/extension code |
| req_addr | input | 32 | Effective address |
| bus_rsp_error | input | 1 | Same-cycle bus error response |
| bus_rsp_data | input | 32 | Same-cycle read data, right-justified |
| bus_req_valid | output | 1 | Bus access issued |
| bus_req_write | output | 1 | Issued access is a write |
| bus_req_addr | output | 32 | Address of the issued access |
| exc_valid | output | 1 | Exception pulse |
| exc_cause | output | 4 | Cause code (2, 4, 5, 6) |
| wb_valid | output | 1 | Load write-back pulse |
| wb_data | output | 32 | Extended load data |
| done_valid | output | 1 | Access completed without exception |

## Verification
The bench sweeps every combination of the following, so that each of the eight width codes meets each of the four byte offsets:
- load or store,
- compressed or not,
- width code,
- address low bits,
- bus error,
- two data words.

The first data word has the sign bits of byte and halfword set and the second has them clear. This separates sign extension from zero extension and byte from halfword selection. Pairing the bus error with misaligned and illegal requests exposes any fault in the cause priority. The compressed runs with odd width codes show whether the forced 4-byte size actually overrides the width code. An idle cycle after each request checks that each result is a one-cycle pulse.

// File: rtl/lsu_chk_pkg.sv
package lsu_chk_pkg;
  localparam int unsigned CAUSE_W = 4;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE        = 4'd0,
    CAUSE_ILLEGAL     = 4'd2,
    CAUSE_LD_MISALIGN = 4'd4,
    CAUSE_LD_FAULT    = 4'd5,
    CAUSE_ST_MISALIGN = 4'd6
  } cause_e;

  typedef struct packed {
    logic [1:0] size_log2;
    logic       is_signed;
    logic       illegal;
  } size_info_t;
endpackage

// File: rtl/lsu_size_decode.sv
module lsu_size_decode
  import lsu_chk_pkg::*;
(
  input  logic       is_store,
  input  logic       compressed,
  input  logic [2:0] width,
  output size_info_t info
);
  always_comb begin
    info.size_log2 = width[1:0];
    info.is_signed = ~width[2];
    info.illegal   = 1'b0;
    if (compressed) begin
      info.size_log2 = 2'd2;
      info.is_signed = 1'b1;
    end else if (is_store) begin
      info.illegal = (width > 3'd2);
    end else begin
      info.illegal = (width == 3'd3) || (width == 3'd6) || (width == 3'd7);
    end
  end
endmodule

// File: rtl/lsu_misalign.sv
module lsu_misalign #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size_log2,
  output logic          misaligned
);
  localparam int unsigned MW = 3;
  logic [MW-1:0] mask;

  always_comb begin
    mask       = MW'((MW'(1) << size_log2) - MW'(1));
    misaligned = |(addr & AW'(mask));
  end
endmodule

// File: rtl/lsu_load_extend.sv
module lsu_load_extend #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] raw,
  input  logic [1:0]    size_log2,
  input  logic          is_signed,
  output logic [DW-1:0] ext
);
  localparam int unsigned BW = 8;
  localparam int unsigned HW = 16;

  always_comb begin
    unique case (size_log2)
      2'd0:    ext = {{(DW-BW){is_signed & raw[BW-1]}}, raw[BW-1:0]};
      2'd1:    ext = {{(DW-HW){is_signed & raw[HW-1]}}, raw[HW-1:0]};
      default: ext = raw;
    endcase
  end
endmodule

// File: rtl/lsu_align_check.sv
module lsu_align_check
  import lsu_chk_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_is_store,
  input  logic               req_compressed,
  input  logic [2:0]         req_width,
  input  logic [AW-1:0]      req_addr,
  input  logic               bus_rsp_error,
  input  logic [DW-1:0]      bus_rsp_data,
  output logic               bus_req_valid,
  output logic               bus_req_write,
  output logic [AW-1:0]      bus_req_addr,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic               wb_valid,
  output logic [DW-1:0]      wb_data,
  output logic               done_valid
);
  size_info_t info;
  logic       misaligned;
  logic [DW-1:0] ext_data;

  lsu_size_decode u_dec (
    .is_store   (req_is_store),
    .compressed (req_compressed),
    .width      (req_width),
    .info       (info)
  );

  lsu_misalign #(.AW(AW)) u_mis (
    .addr       (req_addr),
    .size_log2  (info.size_log2),
    .misaligned (misaligned)
  );

  lsu_load_extend #(.DW(DW)) u_ext (
    .raw        (bus_rsp_data),
    .size_log2  (info.size_log2),
    .is_signed  (info.is_signed),
    .ext        (ext_data)
  );

  // Bus side: only legal, aligned requests leave the block.
  always_comb begin
    bus_req_valid = req_valid & ~info.illegal & ~misaligned;
    bus_req_write = req_is_store;
    bus_req_addr  = req_addr;
  end

  // Next-state of the result registers.
  logic               exc_n, wb_n, done_n, data_en;
  logic [CAUSE_W-1:0] cause_n;
  logic [DW-1:0]      data_n;

  always_comb begin
    exc_n   = 1'b0;
    cause_n = CAUSE_NONE;
    wb_n    = 1'b0;
    done_n  = 1'b0;
    data_n  = '0;
    if (req_valid) begin
      if (info.illegal) begin
        exc_n   = 1'b1;
        cause_n = CAUSE_ILLEGAL;
      end else if (misaligned) begin
        exc_n   = 1'b1;
        cause_n = req_is_store ? CAUSE_ST_MISALIGN : CAUSE_LD_MISALIGN;
      end else if (!req_is_store && bus_rsp_error) begin
        exc_n   = 1'b1;
        cause_n = CAUSE_LD_FAULT;
      end else begin
        done_n = 1'b1;
        wb_n   = ~req_is_store;
        data_n = req_is_store ? '0 : ext_data;
      end
    end
    data_en = wb_n | wb_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_valid  <= 1'b0;
      exc_cause  <= '0;
      wb_valid   <= 1'b0;
      done_valid <= 1'b0;
    end else begin
      exc_valid  <= exc_n;
      exc_cause  <= cause_n;
      wb_valid   <= wb_n;
      done_valid <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_data <= '0;
    end else if (data_en) begin
      wb_data <= data_n;
    end
  end
endmodule

// File: rtl/lsu_align_check_sva.sv
module lsu_align_check_sva #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_is_store,
  input logic          req_compressed,
  input logic [2:0]    req_width,
  input logic [AW-1:0] req_addr,
  input logic          bus_rsp_error,
  input logic          bus_req_valid,
  input logic          exc_valid,
  input logic [3:0]    exc_cause,
  input logic          wb_valid,
  input logic [DW-1:0] wb_data,
  input logic          done_valid
);
  // R2 R4 R7: a word-sized access on the bus is word aligned
  a_r2_word_bus_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && (req_compressed || req_width[1:0] == 2'd2)) |-> (req_addr[1:0] == 2'b00));

  // R9: an illegal store code never reaches the bus
  a_r9_illegal_store_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_store && !req_compressed && req_width[2]) |-> !bus_req_valid);

  // R10: any result follows a request one cycle earlier
  a_r10_result_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid || done_valid) |-> $past(req_valid));

  // R10: at most one of exception and completion
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exc_valid, done_valid}));

  // R2 R3: a load write-back never coincides with an exception
  a_r3_no_wb_on_exc: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> !wb_valid);

  // R5: stores never write back
  a_r5_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_store) |=> !wb_valid);

  // R8: a bus error on an unissued load gives no fault cause
  a_r8_fault_only_if_issued: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_store && bus_rsp_error && !bus_req_valid) |=> (exc_cause != 4'd5));

  // R10: data is cleared outside a write-back pulse
  a_r10_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_valid |-> (wb_data == '0));
endmodule

bind lsu_align_check lsu_align_check_sva #(.AW(AW), .DW(DW)) u_sva (.*);

// File: tb/test_lsu_align_check.sv
module test_lsu_align_check;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_is_store, req_compressed, bus_rsp_error;
  logic [2:0]  req_width;
  logic [31:0] req_addr, bus_rsp_data;
  logic        bus_req_valid, bus_req_write, exc_valid, wb_valid, done_valid;
  logic [31:0] bus_req_addr, wb_data;
  logic [3:0]  exc_cause;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lsu_align_check i_lsu_align_check (
    .clk, .rst_n, .req_valid, .req_is_store, .req_compressed, .req_width,
    .req_addr, .bus_rsp_error, .bus_rsp_data, .bus_req_valid, .bus_req_write,
    .bus_req_addr, .exc_valid, .exc_cause, .wb_valid, .wb_data, .done_valid
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_is_store = 0; req_compressed = 0;
    req_width = 0; req_addr = 0; bus_rsp_error = 0; bus_rsp_data = 0;
    repeat (3) @(negedge clk);
    check("R10 reset", {exc_valid, exc_cause, wb_valid, done_valid, wb_data}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int st = 0; st < 2; st++)
    for (int cm = 0; cm < 2; cm++)
    for (int w = 0; w < 8; w++)
    for (int lo = 0; lo < 4; lo++)
    for (int be = 0; be < 2; be++)
    for (int dv = 0; dv < 2; dv++) begin
      int size, cause;
      bit illegal, mis, issue, wb, sgn;
      logic [31:0] data, exp_data;
      string tag;
      data = dv ? 32'h7A5C_2E71 : 32'hC3F0_80F7;
      size = cm ? 4 : (1 << (w % 4));
      illegal = !cm && (st ? (w > 2) : (w == 3 || w >= 6));
      mis = (lo % size) != 0;
      issue = !illegal && !mis;
      cause = 0;
      if (illegal) cause = 2;
      else if (mis) cause = st ? 6 : 4;
      else if (!st && be) cause = 5;
      wb = issue && !st && !(be != 0);
      sgn = (w < 4);
      if (cm || size == 4) exp_data = data;
      else if (size == 1) exp_data = sgn ? {{24{data[7]}}, data[7:0]} : {24'd0, data[7:0]};
      else exp_data = sgn ? {{16{data[15]}}, data[15:0]} : {16'd0, data[15:0]};
      if (!wb) exp_data = 0;
      if (illegal) tag = (be || lo != 0) ? "R9/R8" : "R9";
      else if (mis) tag = st ? (be ? "R4/R8" : "R4") : (be ? "R2/R8" : "R2");
      else if (st) tag = "R5";
      else if (be) tag = "R3";
      else tag = "R6";
      if (cm) tag = {tag, " R7"};

      req_valid = 1; req_is_store = st[0]; req_compressed = cm[0];
      req_width = w[2:0]; req_addr = {28'hA5C3_F21, 2'(lo[1:0] >> 0) , 2'b00} >> 2 << 2 | 32'(lo);
      bus_rsp_error = be[0]; bus_rsp_data = data;
      #1;
      check({"R1 bus ", tag}, {issue, issue ? st[0] : bus_req_write, bus_req_addr},
                              {bus_req_valid, bus_req_write, req_addr});
      @(negedge clk);
      req_valid = 0; bus_rsp_error = 0;
      check({"R10 result ", tag},
            {exc_valid, exc_cause, done_valid, wb_valid, wb_data},
            {cause != 0, 4'(cause), issue && cause == 0, wb, exp_data});
      @(negedge clk);
      check("R10 pulse", {exc_valid, exc_cause, wb_valid, done_valid, wb_data}, 64'd0);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule